// File: doc/BRIEF.md
# Serial Delta-Sigma Converter Interface Model

This block models the digital side of a 24-bit delta-sigma converter as seen by a host on a three- or four-wire serial link. It is meant as a synthesizable stand-in for testbenches and FPGA prototypes. An external model of the converter core delivers each result on a parallel port with a done strobe. The block then serialises a 32-bit word made of four status bits, the 24-bit result and four sub-LSB bits. The host frames each read with an active-low select.

Between reads the block passes through three phases: converting, sleeping and transferring. While select is low outside a transfer, the data line carries an end-of-conversion flag. Raising select in the middle of a frame aborts the read and starts the next conversion. The serial clock either comes from the host or is generated inside the block by a divider. The choice is made from the level on the clock pin, sampled when reset is released and again at each falling edge of select. With two channels, conversions alternate between them, and the channel that was used is carried in the frame.

Top module: `adc_serial_port`

## Requirements
- R1: While `cs_n` is high, `sdo_en` is low and `sck_oe` is low.
- R2: With `cs_n` low outside a transfer, `sdo_out` is 1 while a conversion runs. It is 0 from the clock cycle after the cycle in which `conv_done` is sampled high.
- R3: A frame is 32 bits, sent most significant first. Bit 31 is 0 (conversion finished). Bit 30 is the channel of the conversion (0 or 1). Bit 29 is the sign input and bit 28 the extended-range input. Bits 27..4 are `conv_result` with its MSB first, and bits 3..0 are `conv_sub`.
- R4: Bit 31 is on `sdo_out` before the first rising SCK edge. Each falling SCK edge advances by exactly one bit.
- R5: On the 32nd falling SCK edge a new conversion starts. `conv_start` is high for exactly one cycle after that edge, and `sdo_out` reads 1 while `cs_n` stays low.
- R6: If `cs_n` rises during a transfer, the transfer ends and `conv_start` pulses in the next cycle.
- R7: A low SCK pin level, sampled at reset release and at each falling edge of `cs_n`, selects the host-driven clock, in which case `sck_oe` stays 0. A high level selects the internal clock.
- R8: In internal clock mode, `sck_oe` rises on entry to the transfer. `sck_out` starts low and toggles every `SCK_HALF` cycles. It gives exactly 32 rising edges, and `sck_oe` stays high for exactly 64*`SCK_HALF` cycles.
- R9: The first conversion after reset reports channel 0 on `conv_chan`. With `NUM_CH`=2, each later conversion, including one started by an abort, uses the other channel.
- R10: SCK edges while `cs_n` is high, and `conv_done` pulses while no conversion runs, leave the pending frame unchanged.
- R11: After a conversion completes, the block stays asleep while `cs_n` is high and starts no new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sck_in | input | 1 | Level on the serial clock pin |
| sck_out | output | 1 | Internally generated serial clock |
| sck_oe | output | 1 | Drive enable for `sck_out` onto the pin |
| sdo_out | output | 1 | Serial data / end-of-conversion level |
| sdo_en | output | 1 | Drive enable for the data pin (low = high impedance) |
| conv_start | output | 1 | One-cycle request to start a conversion |
| conv_chan | output | 1 | Channel of the conversion requested |
| conv_done | input | 1 | Conversion-complete strobe |
| conv_sign | input | 1 | Sign flag of the result |
| conv_exr | input | 1 | Extended-range flag of the result |
| conv_result | input | 24 | Conversion result |
| conv_sub | input | 4 | Sub-LSB bits |

## Verification
The assertions check on every cycle the properties that follow directly from state. These are the level of the end-of-conversion flag during conversion and sleep, the start pulse after a frame end or an abort, the link between the clock drive and the transfer phase, and the frozen frame word while select is high. They also check the channel alternation at each start and the hold of sleep with select high. The bench scenarios are needed for the rest: the bit order and field contents of whole frames, the one-bit-per-falling-edge timing, the period of the internal clock and its count of 32 rising edges, the mode choice made at select falling edges, and whether a frame survives stray clocks and done strobes.

// File: rtl/asp_pkg.sv
package asp_pkg;
  localparam int FRAME_W = 32;
  localparam int RES_W   = 24;
  localparam int SUB_W   = 4;

  typedef enum logic [1:0] {
    ST_CONV  = 2'd0,
    ST_SLEEP = 2'd1,
    ST_XFER  = 2'd2
  } asp_state_e;

  // Frame word: done flag, channel, sign, range, result, sub-LSBs
  function automatic logic [FRAME_W-1:0] pack_frame(
    input logic             ch,
    input logic             sgn,
    input logic             exr,
    input logic [RES_W-1:0] res,
    input logic [SUB_W-1:0] sub
  );
    return {1'b0, ch, sgn, exr, res, sub};
  endfunction
endpackage

// File: rtl/asp_chansel.sv
module asp_chansel #(
  parameter int NUM_CH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic chan
);
  generate
    if (NUM_CH > 1) begin : g_alt
      logic nxt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          nxt_q <= 1'b0;
          chan  <= 1'b0;
        end else if (start) begin
          chan  <= nxt_q;
          nxt_q <= ~nxt_q;
        end
      end
    end else begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     chan <= 1'b0;
        else if (start) chan <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/asp_sckgen.sv
module asp_sckgen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sck,
  output logic fall
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = run && (cnt_q == TOP);
  assign fall = wrap && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else if (!run) begin
      cnt_q <= '0;
      sck   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      sck   <= ~sck;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/asp_shifter.sv
module asp_shifter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  input  logic         shift,
  output logic         msb,
  output logic         last,
  output logic [W-1:0] word
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt_q;

  assign msb  = word[W-1];
  assign last = (cnt_q == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word  <= '1;
      cnt_q <= '0;
    end else if (load) begin
      word  <= din;
      cnt_q <= '0;
    end else if (shift) begin
      word  <= {word[W-2:0], 1'b1};
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import asp_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SCK_HALF = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             sck_in,
  output logic             sck_out,
  output logic             sck_oe,
  output logic             sdo_out,
  output logic             sdo_en,
  output logic             conv_start,
  output logic             conv_chan,
  input  logic             conv_done,
  input  logic             conv_sign,
  input  logic             conv_exr,
  input  logic [RES_W-1:0] conv_result,
  input  logic [SUB_W-1:0] conv_sub
);
  asp_state_e state_q, state_d;
  logic cs_q, sck_q, ext_q, boot_q, start_q;
  logic in_xfer, in_conv, cs_fall;
  logic ext_fall, int_fall, fall_evt, last_bit;
  logic frame_end, abort_evt, start_evt, load_evt;
  logic int_run, shift_msb, int_sck;
  logic [FRAME_W-1:0] shift_word;

  // Named internal events
  assign in_xfer   = (state_q == ST_XFER);
  assign in_conv   = (state_q == ST_CONV);
  assign cs_fall   = cs_q & ~cs_n;
  assign ext_fall  = sck_q & ~sck_in;
  assign fall_evt  = in_xfer & ~cs_n & (ext_q ? ext_fall : int_fall);
  assign frame_end = fall_evt & last_bit;
  assign abort_evt = in_xfer & cs_n;
  assign start_evt = boot_q | frame_end | abort_evt;
  assign load_evt  = in_conv & conv_done & ~boot_q;
  assign int_run   = in_xfer & ~ext_q & ~cs_n;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_CONV:  if (load_evt)  state_d = ST_SLEEP;
      ST_SLEEP: if (!cs_n)     state_d = ST_XFER;
      ST_XFER:  if (start_evt) state_d = ST_CONV;
      default:                 state_d = ST_CONV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_CONV;
      cs_q    <= 1'b1;
      sck_q   <= 1'b0;
      ext_q   <= 1'b1;
      boot_q  <= 1'b1;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cs_q    <= cs_n;
      sck_q   <= sck_in;
      boot_q  <= 1'b0;
      start_q <= start_evt;
      if (boot_q || (cs_fall && !in_xfer)) ext_q <= ~sck_in;
    end
  end

  asp_chansel #(.NUM_CH(NUM_CH)) u_chan (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start_evt),
    .chan  (conv_chan)
  );

  asp_sckgen #(.HALF(SCK_HALF)) u_sck (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (int_run),
    .sck   (int_sck),
    .fall  (int_fall)
  );

  asp_shifter #(.W(FRAME_W)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_evt),
    .din   (pack_frame(conv_chan, conv_sign, conv_exr, conv_result, conv_sub)),
    .shift (fall_evt),
    .msb   (shift_msb),
    .last  (last_bit),
    .word  (shift_word)
  );

  assign sck_out    = int_sck;
  assign sck_oe     = int_run;
  assign sdo_en     = ~cs_n;
  assign sdo_out    = in_xfer ? shift_msb : in_conv;
  assign conv_start = start_q;
endmodule

// File: rtl/asp_checker.sv
module asp_checker
  import asp_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cs_n,
  input logic               sdo_out,
  input logic               sck_oe,
  input logic               conv_start,
  input logic               conv_chan,
  input logic               conv_done,
  input asp_state_e         state_q,
  input logic               frame_end,
  input logic               abort_evt,
  input logic [FRAME_W-1:0] shift_word
);
  logic prev_ch, seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ch <= 1'b0;
      seen_q  <= 1'b0;
    end else if (conv_start) begin
      prev_ch <= conv_chan;
      seen_q  <= 1'b1;
    end
  end

  AST_EOC_WHILE_CONV: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && state_q == ST_CONV) |-> sdo_out); // R2
  AST_EOC_LOW_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && state_q == ST_SLEEP) |-> !sdo_out); // R2
  AST_FRAME_END_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (conv_start && state_q == ST_CONV)); // R5
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R5
  AST_ABORT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (conv_start && state_q == ST_CONV)); // R6
  AST_SCK_DRIVE_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    sck_oe |-> (state_q == ST_XFER && !cs_n)); // R8
  AST_FIRST_CH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !seen_q) |-> !conv_chan); // R9
  AST_CH_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && seen_q && NUM_CH > 1) |-> (conv_chan != prev_ch)); // R9
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !(state_q == ST_CONV && conv_done)) |=> $stable(shift_word)); // R10
  AST_SLEEP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && cs_n) |=> (state_q == ST_SLEEP && !conv_start)); // R11
endmodule

bind adc_serial_port asp_checker #(.NUM_CH(NUM_CH)) u_asp_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs_n       (cs_n),
  .sdo_out    (sdo_out),
  .sck_oe     (sck_oe),
  .conv_start (conv_start),
  .conv_chan  (conv_chan),
  .conv_done  (conv_done),
  .state_q    (state_q),
  .frame_end  (frame_end),
  .abort_evt  (abort_evt),
  .shift_word (shift_word)
);

// File: tb/tb_adc_serial_port.sv
module tb_adc_serial_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int CONV_LAT   = 20;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck_drv = 1'b0;
  logic conv_done = 1'b0, conv_sign = 1'b0, conv_exr = 1'b0;
  logic [23:0] conv_result = '0;
  logic [3:0]  conv_sub = '0;
  wire sck_out, sck_oe, sdo_out, sdo_en, conv_start, conv_chan;
  wire sck_pin = sck_oe ? sck_out : sck_drv;

  adc_serial_port #(.NUM_CH(2), .SCK_HALF(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck_in(sck_pin),
    .sck_out(sck_out), .sck_oe(sck_oe), .sdo_out(sdo_out), .sdo_en(sdo_en),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_sign(conv_sign), .conv_exr(conv_exr), .conv_result(conv_result),
    .conv_sub(conv_sub)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0, n_frames = 0, n_starts = 0;
  logic [31:0] exp_q[$];
  logic nx_sgn = 0, nx_exr = 0;
  logic [23:0] nx_res = '0;
  logic [3:0]  nx_sub = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // Converter model: the driver that pushes expected frames
  int   timer = -1;
  logic exp_ch = 1'b0, cur_ch = 1'b0;
  bit   inj_req = 0;
  always @(negedge clk) begin
    conv_done = 1'b0;
    if (rst_n && conv_start) begin
      check(conv_chan == exp_ch, "R9 channel", {31'd0, conv_chan}, {31'd0, exp_ch});
      n_starts++;
      cur_ch = conv_chan;
      exp_ch = ~exp_ch;
      timer  = CONV_LAT;
    end else if (timer > 0) begin
      timer--;
    end else if (timer == 0) begin
      conv_sign = nx_sgn; conv_exr = nx_exr; conv_result = nx_res; conv_sub = nx_sub;
      conv_done = 1'b1;
      exp_q.push_back({1'b0, cur_ch, nx_sgn, nx_exr, nx_res, nx_sub});
      timer = -1;
    end else if (inj_req) begin
      conv_sign = 1'b1; conv_exr = 1'b1; conv_result = 24'hDEAD01; conv_sub = 4'hC;
      conv_done = 1'b1;
      inj_req = 0;
    end
  end

  // Monitor: collects bits on rising SCK at the pin and compares whole frames
  bit mon_on = 0;
  int mon_bits = 0;
  logic [31:0] mon_word = '0;
  always @(posedge sck_pin) begin
    if (mon_on && !cs_n) begin
      mon_word = {mon_word[30:0], sdo_out};
      mon_bits++;
      if (mon_bits == 32) begin
        mon_on = 0;
        n_frames++;
        if (exp_q.size() == 0) check(1'b0, "R3 frame with none expected", mon_word, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(mon_word == e, "R3 R4 frame", mon_word, e);
        end
      end
    end
  end

  task automatic wait_ready();
    while (exp_q.size() == 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic ext_pulses(input int n);
    mon_bits = 0;
    mon_on   = 1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) sck_drv = 1'b1;
      @(negedge clk);
      @(negedge clk) sck_drv = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic set_next(input logic s, input logic x, input logic [23:0] r, input logic [3:0] b);
    nx_sgn = s; nx_exr = x; nx_res = r; nx_sub = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 32'd0, 32'd1);
    summary();
  end

  initial begin
    set_next(1'b1, 1'b0, 24'hA5C3F1, 4'h9);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sdo_en == 1'b0, "R1 sdo_en after reset", {31'd0, sdo_en}, 32'd0);
    check(sck_oe == 1'b0, "R1 sck_oe after reset", {31'd0, sck_oe}, 32'd0);

    // R2: flag high while converting, low once done
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    check(sdo_out == 1'b1 && sdo_en == 1'b1, "R2 flag while converting", {31'd0, sdo_out}, 32'd1);
    while (exp_q.size() == 0) @(negedge clk);
    @(negedge clk);
    check(sdo_out == 1'b0, "R2 flag after done", {31'd0, sdo_out}, 32'd0);
    repeat (2) @(negedge clk);

    // Frame on CH0, host clock
    ext_pulses(32);
    check(sdo_out == 1'b1, "R5 sdo high after frame", {31'd0, sdo_out}, 32'd1);
    check(conv_start == 1'b1, "R5 start after frame", {31'd0, conv_start}, 32'd1);
    check(sck_oe == 1'b0, "R7 no drive in host mode", {31'd0, sck_oe}, 32'd0);
    set_next(1'b0, 1'b1, 24'hFFF000, 4'h3);

    // Frame on CH1
    wait_ready();
    ext_pulses(32);
    check(conv_start == 1'b1, "R5 start after second frame", {31'd0, conv_start}, 32'd1);
    @(negedge clk);
    check(conv_start == 1'b0, "R5 start is one cycle", {31'd0, conv_start}, 32'd0);
    set_next(1'b1, 1'b1, 24'h000001, 4'hF);

    // R6: abort mid-frame
    wait_ready();
    ext_pulses(10);
    set_next(1'b1, 1'b0, 24'h123456, 4'h6);
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    check(conv_start == 1'b1, "R6 abort starts conversion", {31'd0, conv_start}, 32'd1);
    check(sdo_en == 1'b0, "R1 released while select high", {31'd0, sdo_en}, 32'd0);
    mon_on = 0;
    if (exp_q.size() > 0) void'(exp_q.pop_front());
    @(negedge clk) cs_n = 1'b0;
    @(negedge clk);
    check(sdo_out == 1'b1, "R6 R2 converting after abort", {31'd0, sdo_out}, 32'd1);
    cs_n = 1'b1;

    // R11 / R10: sleep with select high, stray clocks and done strobe
    while (exp_q.size() == 0) @(negedge clk);
    begin
      int s0;
      s0 = n_starts;
      for (int i = 0; i < 4; i++) begin
        @(negedge clk) sck_drv = 1'b1;
        @(negedge clk) sck_drv = 1'b0;
      end
      inj_req = 1;
      repeat (40) @(negedge clk);
      check(n_starts == s0, "R11 no start while asleep", n_starts, s0);
      check(sdo_en == 1'b0, "R1 hi-z while asleep", {31'd0, sdo_en}, 32'd0);
    end
    cs_n = 1'b0;
    @(negedge clk);
    check(sdo_out == 1'b0, "R11 R2 wakes with flag low", {31'd0, sdo_out}, 32'd0);
    repeat (2) @(negedge clk);
    ext_pulses(32); // R10: frame must be the untouched result
    set_next(1'b0, 1'b0, 24'h5A5A5A, 4'hA);

    // R7 / R8: internal clock mode
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk) sck_drv = 1'b1;
    @(negedge clk) cs_n = 1'b0;
    mon_bits = 0;
    mon_on = 1;
    begin
      int idx = -1, rises = 0, r1 = -1, r2 = -1;
      logic prev = 1'b0;
      for (int k = 0; k < 5000; k++) begin
        @(negedge clk);
        if (sck_oe) begin
          idx++;
          if (sck_pin && !prev) begin
            rises++;
            if (r1 < 0) r1 = idx; else if (r2 < 0) r2 = idx;
          end
          prev = sck_pin;
        end else if (idx >= 0) break;
      end
      check(rises == 32, "R8 rising edge count", rises, 32);
      check(r1 == HALF, "R8 first rise delay", r1, HALF);
      check(r2 - r1 == 2 * HALF, "R8 clock period", r2 - r1, 2 * HALF);
      check(idx + 1 == 64 * HALF, "R8 drive window", idx + 1, 64 * HALF);
      check(sdo_out == 1'b1, "R5 sdo high after internal frame", {31'd0, sdo_out}, 32'd1);
    end
    set_next(1'b0, 1'b0, 24'h800000, 4'h1);

    // R7: back to host clock
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk) sck_drv = 1'b0;
    @(negedge clk) cs_n = 1'b0;
    wait_ready();
    check(sck_oe == 1'b0, "R7 host mode reselected", {31'd0, sck_oe}, 32'd0);
    ext_pulses(32);
    check(sdo_out == 1'b1, "R5 sdo high after last frame", {31'd0, sdo_out}, 32'd1);
    repeat (4) @(negedge clk);
    check(n_frames == 5, "R3 frames compared", n_frames, 5);
    summary();
  end
endmodule